// File: doc/BRIEF.md
# Dual-Ratio Oversampled Serial Receiver

This block receives asynchronous 8N1 characters: one low start bit, eight data bits with the least significant bit first, and one high stop bit. It is clocked by the system clock and moves forward only on a one-cycle sample strobe. The strobe always runs at sixteen times the bit rate. A mode input selects how the data bits are sampled. In the 16x mode every strobe is a data-rate sample. In the 8x mode only every second strobe is a data-rate sample, so each bit is built from eight samples.

Qualifying the start bit does not depend on the mode. It always runs on the full sixteen-strobe timeline. The sample counter starts at 1 on the strobe that first sees the line low. The receiver then looks at two groups of samples: positions 3, 5 and 7, and positions 8, 9 and 10. At most one of these six samples may be high. Once the start bit is accepted, the data and stop bits are each resolved by a vote of three samples around the bit centre. The byte is then presented without its start and stop bits.

The output side is a plain valid pulse with no ready signal, so it cannot apply back-pressure. The byte is offered for exactly one clock cycle, and the consumer must take it in that cycle. The data output then keeps its value until the next character completes, but the valid pulse is not repeated.

Top module: `osrx_receiver`

## Requirements
- R1: While reset is asserted, and until the first character completes, `rx_valid_o`, `frame_err_o` and `noise_o` are 0 and `rx_data_o` is all zeros.
- R2: A falling edge is accepted as a start candidate only after the synchronised line has been high on at least 3 consecutive strobes since reset, since the last character ended, or since the last rejected start. If the line stays low without that, no character is ever reported.
- R3: The strobe that first sees the line low is sample 1. The start bit is judged only on samples 3, 5, 7, 8, 9 and 10, in both modes. It is accepted when at most one of these six samples is high.
- R4: If two or more of the six start samples are high, the candidate is dropped. No valid pulse is produced for it, and edge search resumes.
- R5: If exactly one of the six start samples is high, the character is still received, and `noise_o` pulses together with its valid pulse. Otherwise `noise_o` stays 0.
- R6: In 16x mode each bit lasts 16 strobes. The bit value is the majority of strobes 7, 8 and 9, counted within the bit from 1.
- R7: In 8x mode each bit lasts 8 data-rate samples (one sample on every second strobe). The bit value is the majority of data-rate samples 3, 4 and 5, which are strobes 6, 8 and 10 of the bit.
- R8: Bit 0 of `rx_data_o` is the first data bit after the start bit, and bit 7 is the last one. The start and stop bits are not part of the byte.
- R9: `rx_valid_o` is high for exactly one cycle per accepted character. It is raised at the clock edge that registers the final stop-bit sample (strobe 9 of the stop bit in 16x mode, strobe 10 in 8x mode), plus the input synchroniser delay. `rx_data_o` keeps its value until the next character completes.
- R10: If the stop bit resolves to 0, `frame_err_o` pulses in the same cycle as `rx_valid_o`, and the byte is still delivered.
- R11: `mode8_i` is taken into account only while the receiver is hunting for an edge. A change during a character takes effect from the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| mode8_i | input | 1 | 1 selects 8x data sampling, 0 selects 16x |
| tick16_i | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_data_o | output | 8 | Last received byte, held until the next one |
| rx_valid_o | output | 1 | One-cycle pulse when a byte is delivered |
| frame_err_o | output | 1 | Pulse with valid when the stop bit read as 0 |
| noise_o | output | 1 | Pulse with valid when one start sample disagreed |

## Verification
Every result of this block is due on the clock edge that registers the final stop-bit sample. In 16x mode that is strobe 9 of the stop bit, and in 8x mode it is strobe 10. That strobe is 144 plus 9 or 10 strobes after the first low sample of the start bit. The bench numbers each driven strobe and records the strobe number when it sees the valid pulse. It checks that number against this computed position. It reads the data and flag outputs half a clock after that edge. A rejected start produces no result at all, so for that case the bench drives a long high line and then confirms that the pulse count did not change.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  localparam int OSR       = 16;            // strobes per bit, fixed timeline
  localparam int PW        = $clog2(OSR) + 1;
  localparam int CENTER    = OSR / 2;       // mid-bit strobe
  localparam int START_END = 10;            // last strobe of the start check

  typedef enum logic [0:0] {Q_HUNT, Q_CHECK} qual_st_e;

  // Strobes of the start bit that take part in the decision.
  function automatic logic start_slot(input logic [PW-1:0] p);
    return p inside {PW'(3), PW'(5), PW'(7), PW'(8), PW'(9), PW'(10)};
  endfunction

  // 0: not a sample point, 1: first vote, 2: second vote, 3: final vote.
  function automatic logic [1:0] data_slot(input logic mode8, input logic [PW-1:0] p);
    logic [PW-1:0] step;
    step = mode8 ? PW'(2) : PW'(1);
    if (p == PW'(CENTER) - step) return 2'd1;
    if (p == PW'(CENTER))        return 2'd2;
    if (p == PW'(CENTER) + step) return 2'd3;
    return 2'd0;
  endfunction
endpackage

// File: rtl/osrx_vote3.sv
module osrx_vote3 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic y_o
);
  always_comb y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/osrx_start_qual.sv
module osrx_start_qual
  import osrx_pkg::*;
#(
  parameter int IDLE_HIGHS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic hold_i,
  output logic go_o,
  output logic noisy_o,
  output logic hunting_o
);
  localparam int HW = $clog2(IDLE_HIGHS + 1);

  qual_st_e       st_q;
  logic [HW-1:0]  hc_q;
  logic [PW-1:0]  pos_q;
  logic [2:0]     ones_q;
  logic           noisy_q;

  logic [PW-1:0]  pos_n;
  logic           hit;
  logic [2:0]     ones_n;

  always_comb begin
    pos_n  = pos_q + PW'(1);
    hit    = start_slot(pos_n) & rx_i;
    ones_n = ones_q + {2'b00, hit};
    go_o   = tick_i && (st_q == Q_CHECK) && (pos_n == PW'(OSR));
  end

  assign noisy_o   = noisy_q;
  assign hunting_o = (st_q == Q_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= Q_HUNT;
      hc_q    <= '0;
      pos_q   <= '0;
      ones_q  <= '0;
      noisy_q <= 1'b0;
    end else if (tick_i) begin
      case (st_q)
        Q_HUNT: begin
          if (hold_i) begin
            hc_q <= '0;
          end else if (rx_i) begin
            if (hc_q != HW'(IDLE_HIGHS)) hc_q <= hc_q + HW'(1);
          end else if (hc_q == HW'(IDLE_HIGHS)) begin
            st_q   <= Q_CHECK;
            pos_q  <= PW'(1);
            ones_q <= '0;
            hc_q   <= '0;
          end else begin
            hc_q <= '0;
          end
        end
        default: begin
          pos_q  <= pos_n;
          ones_q <= ones_n;
          if (pos_n == PW'(START_END)) begin
            if (ones_n >= 3'd2) st_q <= Q_HUNT;
            else                noisy_q <= (ones_n == 3'd1);
          end
          if (pos_n == PW'(OSR)) st_q <= Q_HUNT;
        end
      endcase
    end
  end

  AST_GO_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> (ones_q <= 3'd1));  // R4
  AST_CHECK_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == Q_CHECK) |-> (pos_q >= PW'(1) && pos_q < PW'(OSR)));  // R3
  AST_EDGE_AFTER_HIGHS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == Q_CHECK) |-> ($past(hc_q) == HW'(IDLE_HIGHS)));  // R2
endmodule

// File: rtl/osrx_bit_engine.sv
module osrx_bit_engine
  import osrx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 mode8_i,
  input  logic                 go_i,
  input  logic                 noisy_i,
  output logic                 busy_o,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o,
  output logic                 noise_o
);
  localparam int IW = $clog2(DATA_BITS + 1);

  logic                 busy_q;
  logic [PW-1:0]        tcnt_q;
  logic [IW-1:0]        idx_q;
  logic [1:0]           smp_q;
  logic [DATA_BITS-1:0] sh_q;

  logic [PW-1:0]        pos_n;
  logic [1:0]           slot;
  logic                 bit_v;

  always_comb begin
    pos_n = tcnt_q + PW'(1);
    slot  = data_slot(mode8_i, pos_n);
  end

  osrx_vote3 u_vote (
    .a_i (smp_q[0]),
    .b_i (smp_q[1]),
    .c_i (rx_i),
    .y_o (bit_v)
  );

  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
      if (go_i) begin
        busy_q <= 1'b1;
        tcnt_q <= '0;
        idx_q  <= '0;
      end else if (busy_q && tick_i) begin
        tcnt_q <= (pos_n == PW'(OSR)) ? '0 : pos_n;
        if (pos_n == PW'(OSR)) idx_q <= idx_q + IW'(1);
        case (slot)
          2'd1: smp_q[0] <= rx_i;
          2'd2: smp_q[1] <= rx_i;
          2'd3: begin
            if (idx_q == IW'(DATA_BITS)) begin
              valid_o <= 1'b1;
              data_o  <= sh_q;
              ferr_o  <= ~bit_v;
              noise_o <= noisy_i;
              busy_q  <= 1'b0;
            end else begin
              sh_q <= {bit_v, sh_q[DATA_BITS-1:1]};
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);  // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);  // R9
  AST_VALID_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!busy_q && $past(busy_q)));  // R9
  AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |-> valid_o);  // R10
  AST_NOISE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    noise_o |-> valid_o);  // R5
endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_HIGHS  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  input  logic                 mode8_i,
  input  logic                 tick16_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 frame_err_o,
  output logic                 noise_o
);
  logic rx_s;
  logic mode_q;
  logic go;
  logic noisy;
  logic hunting;
  logic eng_busy;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= (sync_q << 1) | SYNC_STAGES'(rx_i);
      end
      assign rx_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // Ratio is frozen for the whole character.
  always_ff @(posedge clk) begin
    if (!rst_n)                    mode_q <= 1'b0;
    else if (hunting && !eng_busy) mode_q <= mode8_i;
  end

  osrx_start_qual #(
    .IDLE_HIGHS (IDLE_HIGHS)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick16_i),
    .rx_i      (rx_s),
    .hold_i    (eng_busy),
    .go_o      (go),
    .noisy_o   (noisy),
    .hunting_o (hunting)
  );

  osrx_bit_engine #(
    .DATA_BITS (DATA_BITS)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick16_i),
    .rx_i    (rx_s),
    .mode8_i (mode_q),
    .go_i    (go),
    .noisy_i (noisy),
    .busy_o  (eng_busy),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .ferr_o  (frame_err_o),
    .noise_o (noise_o)
  );

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(mode_q));  // R11
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !go);  // R3
endmodule

// File: tb/osrx_receiver_bench.sv
module osrx_receiver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b0;
  logic       mode8 = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, ferr, noise;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  int base   = 0;
  int vcnt   = 0;
  int cap_idx = 0;
  logic [7:0] cap_d;
  logic cap_f, cap_n;

  always #5 clk = ~clk;

  osrx_receiver u_osrx_receiver (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .mode8_i(mode8), .tick16_i(tick),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .frame_err_o(ferr), .noise_o(noise)
  );

  typedef struct packed {
    logic        m8;
    logic [7:0]  d;
    logic [15:0] sf;   // bit k-1 flips start sample k high
    logic [15:0] bf;   // bit k-1 flips strobe k of data bit 0
    logic        stp;
    logic        ev;
    logic [7:0]  ed;
    logic        ef;
    logic        en;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'hA5, 16'h0000, 16'h0000, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{1'b1, 8'h3C, 16'h0000, 16'h0000, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{1'b0, 8'h01, 16'h0010, 16'h0000, 1'b1, 1'b1, 8'h01, 1'b0, 1'b1},
    '{1'b1, 8'h80, 16'h0100, 16'h0000, 1'b1, 1'b1, 8'h80, 1'b0, 1'b1},
    '{1'b0, 8'h55, 16'h0000, 16'h0000, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0},
    '{1'b0, 8'hFF, 16'h0000, 16'h00C0, 1'b1, 1'b1, 8'hFE, 1'b0, 1'b0},
    '{1'b1, 8'h00, 16'h0000, 16'h0140, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'h00, 16'h0000, 16'h0220, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},
    '{1'b0, 8'h00, 16'h0104, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'h00, 16'h0014, 16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'h5A, 16'h0200, 16'h0000, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b1}
  };

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt++;
      cap_idx = idx;
      cap_d = rx_data;
      cap_f = ferr;
      cap_n = noise;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One strobe period of line value v; called and returns at a negedge.
  task automatic drive(input logic v);
    rx = v;
    idx = idx + 1;
    @(negedge clk); @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic m, input logic m_after, input logic [7:0] d,
                            input logic [15:0] sf, input logic [15:0] bf,
                            input logic stp, input logic reject);
    mode8 = m;
    for (int i = 0; i < 4; i++) drive(1'b1);
    base = idx;
    for (int k = 1; k <= 16; k++) begin
      if (k == 2) mode8 = m_after;
      drive(sf[k-1]);
    end
    if (reject) begin
      for (int i = 0; i < 160; i++) drive(1'b1);
    end else begin
      for (int b = 0; b < 8; b++)
        for (int k = 1; k <= 16; k++)
          drive((b == 0 && bf[k-1]) ? ~d[b] : d[b]);
      for (int k = 1; k <= 16; k++) drive(stp);
      for (int i = 0; i < 4; i++) drive(1'b1);
    end
  endtask

  task automatic expect_frame(input string dtag, input int v0, input logic m,
                              input logic [7:0] ed, input logic ef, input logic en);
    chk("R9 pulse count", vcnt - v0, 1);
    chk(dtag, cap_d, ed);
    chk("R10 frame error", cap_f, ef);
    chk("R3/R5 noise flag", cap_n, en);
    chk("R9 result strobe", cap_idx, base + 144 + (m ? 10 : 9));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", rx_valid, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 noise", noise, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: line never high for 3 strobes before the low, so no character
    v0 = vcnt;
    for (int i = 0; i < 20; i++) drive(1'b0);
    drive(1'b1); drive(1'b1);
    for (int i = 0; i < 144; i++) drive(1'b0);
    for (int i = 0; i < 24; i++) drive(1'b1);
    chk("R2 no start without idle highs", vcnt - v0, 0);
    chk("R1 data still clear", rx_data, 0);

    // Table walk
    for (int n = 0; n < NV; n++) begin
      v0 = vcnt;
      send_frame(VT[n].m8, VT[n].m8, VT[n].d, VT[n].sf, VT[n].bf, VT[n].stp, ~VT[n].ev);
      if (VT[n].ev)
        expect_frame(VT[n].m8 ? "R7/R8 data" : "R6/R8 data", v0, VT[n].m8,
                     VT[n].ed, VT[n].ef, VT[n].en);
      else
        chk("R4 rejected start", vcnt - v0, 0);
    end

    // R9: byte held after the pulse
    chk("R9 data held", rx_data, 8'h5A);

    // R11: mode change mid-character ignored until the next one
    v0 = vcnt;
    send_frame(1'b0, 1'b1, 8'h00, 16'h0000, 16'h0220, 1'b1, 1'b0);
    expect_frame("R11 old ratio kept", v0, 1'b0, 8'h00, 1'b0, 1'b0);
    v0 = vcnt;
    send_frame(1'b1, 1'b1, 8'h00, 16'h0000, 16'h0220, 1'b1, 1'b0);
    expect_frame("R11 new ratio applied", v0, 1'b1, 8'h01, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule